// File: doc/BRIEF.md
# Gated 16-bit timer/counter with prescaler

This block is a 16-bit up-counter for a microcontroller-style peripheral space. It counts either a one-cycle internal tick input or rising edges of an external clock pin, after a divide-by-1/2/4/8 prescaler. Counting can be made to depend on a gate signal. The gate is taken from a gate pin or from a comparator output, and its polarity is selectable. When the count passes from 0xFFFF to 0x0000 an overflow flag is set. An interrupt request follows the flag when three enable inputs allow it.

Software reaches the block through a byte-wide register port. Address 0 is the control register, address 1 is the low count byte and address 2 is the high count byte. Reads are combinational. A write takes effect at the clock edge where `regWe` is high.

The external clock can take one of two paths to the edge detector. The synchronous path has two retiming flops. The asynchronous path is a single sampling flop and so has lower latency. In both cases the counter must see a falling edge after it is enabled before it counts a rising edge.

Top module: `gtmr_top`

## Requirements
- R1: After reset, the control register, both count bytes and `ovfFlag` are 0, and `irq` is 0.
- R2: Control bit 0 turns the timer on. With bit 0 at 1 and bit 1 at 0 (internal tick mode), the count advances once for each clock cycle in which `tickIn` is high, before prescaling. With bit 0 at 0, the count does not change.
- R3: An increment from 0xFFFF gives 0x0000 and sets `ovfFlag`. The flag stays set until a cycle with `flagClr` high. If a wrap and a clear fall in the same cycle, the wrap wins.
- R4: `irq` is 1 exactly when `ovfFlag`, `timerIe`, `periphIe` and `globalIe` are all 1.
- R5: Control bits 5:4 set the prescale ratio: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8 counted events per count increment.
- R6: When control bit 1 is 1, the block counts rising edges of `extClk` and ignores `tickIn`. A rising edge is counted only if a falling edge has been seen since the timer was last turned on or put into this mode.
- R7: A write to either count byte clears the hidden prescale counter.
- R8: At a clock edge, a count-byte write beats an increment in the same cycle. Reads give: address 0 the control register, address 1 the low byte of the live count, address 2 the high byte, and address 3 zero.
- R9: When control bit 6 is 1, counting happens only while the selected gate is active. Bit 3 selects the gate source: 0 is `gatePin` and 1 is `cmpOut`. Bit 7 inverts the gate: 0 makes it active-high and 1 makes it active-low.
- R10: Control bit 2 selects the external clock path. With bit 2 at 0 (synchronous), a rising edge of `extClk` set up before clock edge 1 shows in the count after clock edge 3. With bit 2 at 1 (asynchronous), it shows after clock edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address: 0 control, 1 low count, 2 high count |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| tickIn | input | 1 | Internal instruction-cycle tick |
| extClk | input | 1 | External clock input |
| gatePin | input | 1 | Gate pin |
| cmpOut | input | 1 | Comparator output used as a gate |
| flagClr | input | 1 | Clears the overflow flag |
| timerIe | input | 1 | Timer interrupt enable |
| periphIe | input | 1 | Peripheral interrupt enable |
| globalIe | input | 1 | Global interrupt enable |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, tick-driven increments, the overflow flag and the prescaler clear all take effect at the edge where the stimulus is held. The bench therefore drives each stimulus at the falling edge and reads back one time unit after the next rising edge. `irq` and the read data are combinational, so they are checked in the same half-cycle as the stimulus that changes them. External clock edges reach the count after three clock edges on the synchronous path and after two on the asynchronous path. The bench checks that the count has not yet changed one edge earlier and has changed at the due edge. It holds each `extClk` level for several cycles in the functional tests.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  parameter int BYTE_W = 8;
  parameter int PRE_W = 3;
  localparam int CNT_W = 2 * BYTE_W;

  typedef struct packed {
    logic              incr;
    logic              preClr;
    logic              wrLo;
    logic              wrHi;
    logic [BYTE_W-1:0] wrData;
  } strobeT;
endpackage

// File: rtl/gtmr_ctrl.sv
module gtmr_ctrl
  import gtmr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic              tickIn,
  input  logic              extClk,
  input  logic              gatePin,
  input  logic              cmpOut,
  output logic [BYTE_W-1:0] ctrlReg,
  output strobeT            strb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   extSample, extPrev, extRise, extFall, armed;
  logic [PRE_W-1:0]       preQ, preMask;
  logic                   tmrOn, extMode, asyncMode, gateSrc, gateEn, gateInv;
  logic                   gateOk, countEvent;

  assign tmrOn     = ctrlReg[0];
  assign extMode   = ctrlReg[1];
  assign asyncMode = ctrlReg[2];
  assign gateSrc   = ctrlReg[3];
  assign gateEn    = ctrlReg[6];
  assign gateInv   = ctrlReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (regWe && regAddr == 2'd0) ctrlReg <= regWdata;
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else syncQ <= {syncQ[SYNC_STAGES-2:0], extClk};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else syncQ <= extClk;
      end
    end
  endgenerate

  assign extSample = asyncMode ? syncQ[0] : syncQ[SYNC_STAGES-1];
  assign extRise   = extSample && !extPrev;
  assign extFall   = !extSample && extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPrev <= 1'b0;
      armed   <= 1'b0;
    end else begin
      extPrev <= extSample;
      if (!tmrOn || !extMode) armed <= 1'b0;
      else if (extFall) armed <= 1'b1;
    end
  end

  assign gateOk     = !gateEn || (((gateSrc ? cmpOut : gatePin)) ^ gateInv);
  assign countEvent = tmrOn && gateOk && (extMode ? (extRise && armed) : tickIn);

  always_comb begin
    preMask = '0;
    for (int i = 0; i < PRE_W; i++) preMask[i] = (i < 32'(ctrlReg[5:4]));
  end

  assign strb.wrLo   = regWe && regAddr == 2'd1;
  assign strb.wrHi   = regWe && regAddr == 2'd2;
  assign strb.wrData = regWdata;
  assign strb.preClr = strb.wrLo || strb.wrHi;
  assign strb.incr   = countEvent && (preQ >= preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preQ <= '0;
    else if (strb.preClr) preQ <= '0;
    else if (countEvent) preQ <= (preQ >= preMask) ? '0 : preQ + 1'b1;
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rstN) strb.preClr |=> preQ == '0); // R7
  AST_GATE_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn && !((gateSrc ? cmpOut : gatePin) ^ gateInv)) |=> $stable(preQ)); // R9
  AST_EXT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && !armed) |-> !strb.incr); // R6
endmodule

// File: rtl/gtmr_data.sv
module gtmr_data
  import gtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [BYTE_W-1:0] ctrlReg,
  input  logic [1:0]        regAddr,
  input  logic              flagClr,
  input  logic              timerIe,
  input  logic              periphIe,
  input  logic              globalIe,
  output logic [BYTE_W-1:0] regRdata,
  output logic              ovfFlag,
  output logic              irq
);
  logic [CNT_W-1:0] cnt;
  logic             anyWr, wrapNow;

  assign anyWr   = strb.wrLo || strb.wrHi;
  assign wrapNow = strb.incr && !anyWr && (&cnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (anyWr) begin
      if (strb.wrLo) cnt[BYTE_W-1:0] <= strb.wrData;
      if (strb.wrHi) cnt[CNT_W-1:BYTE_W] <= strb.wrData;
    end else if (strb.incr) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (wrapNow) ovfFlag <= 1'b1;
    else if (flagClr) ovfFlag <= 1'b0;
  end

  assign irq = ovfFlag && timerIe && periphIe && globalIe;

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = ctrlReg;
      2'd1:    regRdata = cnt[BYTE_W-1:0];
      2'd2:    regRdata = cnt[CNT_W-1:BYTE_W];
      default: regRdata = '0;
    endcase
  end

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incr && !anyWr && cnt == '1) |=> (ovfFlag && cnt == '0)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLo |=> cnt[BYTE_W-1:0] == $past(strb.wrData)); // R8
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[0] && !anyWr) |=> $stable(cnt)); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN) irq |-> ovfFlag); // R4
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic        tickIn,
  input  logic        extClk,
  input  logic        gatePin,
  input  logic        cmpOut,
  input  logic        flagClr,
  input  logic        timerIe,
  input  logic        periphIe,
  input  logic        globalIe,
  output logic        ovfFlag,
  output logic        irq
);
  strobeT            strb;
  logic [BYTE_W-1:0] ctrlReg;

  gtmr_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .tickIn(tickIn), .extClk(extClk), .gatePin(gatePin), .cmpOut(cmpOut),
    .ctrlReg(ctrlReg), .strb(strb)
  );

  gtmr_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlReg(ctrlReg), .regAddr(regAddr),
    .flagClr(flagClr), .timerIe(timerIe), .periphIe(periphIe), .globalIe(globalIe),
    .regRdata(regRdata), .ovfFlag(ovfFlag), .irq(irq)
  );
endmodule

// File: tb/tb_gtmr_top.sv
`timescale 1ns/1ps
module tb_gtmr_top;
  logic clk = 0, rstN = 0, regWe = 0;
  logic [1:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic tickIn = 0, extClk = 0, gatePin = 0, cmpOut = 0, flagClr = 0;
  logic timerIe = 0, periphIe = 0, globalIe = 0, ovfFlag, irq;
  int total = 0, bad = 0;
  bit finished = 0;

  gtmr_top dut (.*);

  always #4 clk = ~clk;

  // ctrl[33:26] gatePin[25] cmpOut[24] ticks[23:16] expected count[15:0]
  localparam logic [33:0] VEC [12] = '{
    {8'h01, 1'b0, 1'b0, 8'd5,  16'd5},  // R2
    {8'h11, 1'b0, 1'b0, 8'd5,  16'd2},  // R5 div2
    {8'h21, 1'b0, 1'b0, 8'd9,  16'd2},  // R5 div4
    {8'h31, 1'b0, 1'b0, 8'd17, 16'd2},  // R5 div8
    {8'h00, 1'b0, 1'b0, 8'd5,  16'd0},  // R2 off
    {8'h41, 1'b0, 1'b0, 8'd4,  16'd0},  // R9 pin low
    {8'h41, 1'b1, 1'b0, 8'd4,  16'd4},  // R9 pin high
    {8'hC1, 1'b1, 1'b0, 8'd4,  16'd0},  // R9 inverted
    {8'hC1, 1'b0, 1'b0, 8'd4,  16'd4},  // R9 inverted low
    {8'h49, 1'b1, 1'b0, 8'd4,  16'd0},  // R9 cmp source low
    {8'h49, 1'b0, 1'b1, 8'd3,  16'd3},  // R9 cmp source high
    {8'h03, 1'b0, 1'b0, 8'd5,  16'd0}   // R6 tickIn ignored
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 0;
  endtask

  task automatic rdCount(output logic [15:0] v);
    @(negedge clk);
    regAddr = 2'd1; #1; v[7:0] = regRdata;
    regAddr = 2'd2; #1; v[15:8] = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickIn = 1;
    end
    @(negedge clk); tickIn = 0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic extLevel(input logic v);
    @(negedge clk); extClk = v; cycles(5);
  endtask

  task automatic zeroCount();
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    cycles(3);
    // R1 reset state
    regAddr = 0; #1; check("R1 ctrl", regRdata, 0);
    rdCount(c); check("R1 count", c, 0);
    check("R1 flag", ovfFlag, 0); check("R1 irq", irq, 0);
    @(negedge clk); rstN = 1;

    foreach (VEC[i]) begin
      wr(2'd0, VEC[i][33:26]);
      gatePin = VEC[i][25]; cmpOut = VEC[i][24];
      zeroCount();
      ticks(int'(VEC[i][23:16]));
      rdCount(c);
      check($sformatf("R2/R5/R6/R9 vector %0d", i), c, VEC[i][15:0]);
    end
    gatePin = 0; cmpOut = 0;

    // R8 read of control and address 3
    @(negedge clk); regAddr = 2'd0; #1; check("R8 ctrl read", regRdata, 8'h03);
    regAddr = 2'd3; #1; check("R8 addr3 read", regRdata, 0);

    // R3 wrap and sticky flag
    wr(2'd0, 8'h01); wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
    ticks(2); rdCount(c);
    check("R3 wrap count", c, 0); check("R3 flag set", ovfFlag, 1);
    ticks(3); check("R3 flag sticky", ovfFlag, 1);
    // R4 interrupt enables
    check("R4 irq no enables", irq, 0);
    @(negedge clk); timerIe = 1; periphIe = 1; #1; check("R4 irq two enables", irq, 0);
    globalIe = 1; #1; check("R4 irq all enables", irq, 1);
    periphIe = 0; #1; check("R4 irq periph off", irq, 0);
    periphIe = 1;
    @(negedge clk); flagClr = 1; @(negedge clk); flagClr = 0;
    check("R3 flag cleared", ovfFlag, 0); check("R4 irq after clear", irq, 0);
    timerIe = 0; periphIe = 0; globalIe = 0;

    // R7 count write clears prescaler
    wr(2'd0, 8'h31); zeroCount();
    ticks(5); wr(2'd1, 8'h00);
    ticks(7); rdCount(c); check("R7 after clear 7 ticks", c, 0);
    ticks(1); rdCount(c); check("R7 eighth tick", c, 1);

    // R8 write beats increment
    wr(2'd0, 8'h01);
    @(negedge clk); tickIn = 1; regWe = 1; regAddr = 2'd1; regWdata = 8'h55;
    @(posedge clk); #1; regWe = 0; tickIn = 0;
    rdCount(c); check("R8 write wins", c, 16'h0055);

    // R6 sync external counting, needs falling edge first
    extClk = 0; wr(2'd0, 8'h00); zeroCount(); wr(2'd0, 8'h03);
    extLevel(1); rdCount(c); check("R6 first rise ignored", c, 0);
    extLevel(0); extLevel(1); rdCount(c); check("R6 rise after fall", c, 1);
    extLevel(0); extLevel(1); extLevel(0); extLevel(1);
    rdCount(c); check("R6 three edges", c, 3);
    // R10 sync latency
    extLevel(0);
    @(negedge clk); extClk = 1;
    @(posedge clk); @(posedge clk); #1; rdCount(c); check("R10 sync not yet", c, 3);
    @(posedge clk); #1; rdCount(c); check("R10 sync due", c, 4);
    extLevel(1);

    // R10 async path
    extClk = 1; wr(2'd0, 8'h00); zeroCount(); wr(2'd0, 8'h07);
    extLevel(0); extLevel(1); rdCount(c); check("R6 async high at enable", c, 1);
    extLevel(0);
    @(negedge clk); extClk = 1;
    @(posedge clk); #1; rdCount(c); check("R10 async not yet", c, 1);
    @(posedge clk); #1; rdCount(c); check("R10 async due", c, 2);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule